// File: doc/BRIEF.md
# Keyboard Matrix Row Latch

This block connects a keyboard matrix of five rows by eight columns to a 16-bit register bus. Software picks the columns to scan by writing an active-low column-drive register: a zero in bit c means column c is driven. The pressed-key state of the whole matrix enters the block as a flat 40-bit vector. The block works out which rows see a pressed key in a driven column and holds the result in an active-low row latch. Its idle value is 0x1F, meaning no row is hit.

A one-bit mask and a clock-enable input gate the keyboard interrupt. The interrupt status register is not stored. It is derived from the row latch and the mask each time it is read. The row latch is re-evaluated one clock after any of these events: a column-register write, a mask write, a change in the key vector, or a rising clock-enable. The result is based on the key vector and column register as they stood after the triggering edge.

The register bus is a plain control path, not a stream. A write takes effect at the clock edge where `bus_wr_en` is high. Read data is a combinational function of `bus_addr`, with no wait states and no back-pressure. Register offsets are in bytes: 0x10 row latch (read-only), 0x14 column drive, 0x20 interrupt status (read-only), 0x28 mask.

Top module: `kbd_scan_latch`

## Requirements
- R1: After reset, the row latch reads 0x1F, the column register reads 0xFF, the mask reads 0, the status reads 0 and `kbd_irq` is low.
- R2: A write to offset 0x14 stores `bus_wdata[7:0]` as the column-drive register, and a read of 0x14 returns it in bits 7:0 with bits 15:8 zero. Bit c = 0 means column c is driven.
- R3: Row latch bit r (read at 0x10, bits 4:0, bits 15:5 zero) is 0 exactly when some key with bit r*8+c set in `key_state` lies in a column c whose drive bit is 0. A pressed key in an undriven column has no effect.
- R4: The row latch is re-evaluated on a column write, a mask write, a change of `key_state`, or a rising `scan_clk_en`. At any other edge it keeps its value.
- R5: A write to offset 0x28 keeps only `bus_wdata[0]` as the mask. A read of 0x28 returns the mask in bit 0 with all other bits zero.
- R6: A read of offset 0x20 returns 1 in bit 0 when the row latch is not 0x1F and the mask is 0, and returns 0 otherwise. Bits 15:1 are always zero.
- R7: `kbd_irq` is high exactly when the row latch is not 0x1F, the mask is 0 and `scan_clk_en` is high. It follows `scan_clk_en` in the same cycle.
- R8: A write to 0x10, to 0x20, or to any offset other than 0x14 and 0x28 changes no register. A read of any unmapped offset returns 0.
- R9: After a triggering edge E, the row latch shows the new result from edge E+1. Between E and E+1 it still shows the previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_clk_en | input | 1 | Scan clock enable; gates the interrupt, and a rise re-evaluates the rows |
| key_state | input | 40 | Pressed-key vector, bit row*8+col set while pressed |
| bus_addr | input | 8 | Register byte offset |
| bus_wr_en | input | 1 | Write strobe, takes effect at the clock edge |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| kbd_irq | output | 1 | Keyboard interrupt, active high level |

## Verification
Two events can fall in the same cycle: a register write that triggers re-evaluation (the column drive or the mask), and a change in `key_state`. Both must resolve into a single update one cycle later. The bench provokes this with directed steps that drive a column write and a new key vector on the same edge, and then a mask write together with a key change. Its behavioural model computes the latch from the key vector and column register it saw at the previous edge. That result is compared every clock against the row latch, status, mask and interrupt, so a lost or doubled evaluation shows as a miscompare.

// File: rtl/kbd_scan_pkg.sv
package kbd_scan_pkg;

  localparam logic [15:0] OFS_ROWS = 16'h0010;
  localparam logic [15:0] OFS_COLS = 16'h0014;
  localparam logic [15:0] OFS_STAT = 16'h0020;
  localparam logic [15:0] OFS_MASK = 16'h0028;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_ROWS,
    SEL_COLS,
    SEL_STAT,
    SEL_MASK
  } kbd_reg_e;

  function automatic kbd_reg_e kbd_decode(input logic [15:0] ofs);
    kbd_reg_e s;
    case (ofs)
      OFS_ROWS: s = SEL_ROWS;
      OFS_COLS: s = SEL_COLS;
      OFS_STAT: s = SEL_STAT;
      OFS_MASK: s = SEL_MASK;
      default:  s = SEL_NONE;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/kbd_scan_regs.sv
module kbd_scan_regs
  import kbd_scan_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int ROWS   = 5,
  parameter int COLS   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr_en,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [ROWS-1:0]   row_latch_n,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [COLS-1:0]   col_drive_n,
  output logic              kbd_mask,
  output logic              col_wr,
  output logic              mask_wr,
  output logic              irq_pending
);

  kbd_reg_e sel;

  // Offsets are compared as 16-bit values whatever the bus width.
  assign sel     = kbd_decode(16'(bus_addr));
  assign col_wr  = bus_wr_en && (sel == SEL_COLS);
  assign mask_wr = bus_wr_en && (sel == SEL_MASK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_drive_n <= '1;
      kbd_mask    <= 1'b0;
    end else begin
      if (col_wr)  col_drive_n <= bus_wdata[COLS-1:0];
      if (mask_wr) kbd_mask    <= bus_wdata[0];
    end
  end

  // Status is derived, never stored: any low row bit counts as a hit.
  assign irq_pending = (row_latch_n != '1) && !kbd_mask;

  always_comb begin
    bus_rdata = '0;
    case (sel)
      SEL_ROWS: bus_rdata[ROWS-1:0] = row_latch_n;
      SEL_COLS: bus_rdata[COLS-1:0] = col_drive_n;
      SEL_STAT: bus_rdata[0]        = irq_pending;
      SEL_MASK: bus_rdata[0]        = kbd_mask;
      default:  bus_rdata           = '0;
    endcase
  end

endmodule

// File: rtl/kbd_scan_trigger.sv
module kbd_scan_trigger #(
  parameter int NKEYS = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scan_clk_en,
  input  logic [NKEYS-1:0] key_state,
  input  logic             col_wr,
  input  logic             mask_wr,
  output logic [NKEYS-1:0] keys_q,
  output logic             eval_pend
);

  logic ce_q;
  logic key_chg;
  logic ce_rise;

  assign key_chg = (key_state != keys_q);
  assign ce_rise = scan_clk_en && !ce_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      keys_q    <= '0;
      ce_q      <= 1'b0;
      eval_pend <= 1'b0;
    end else begin
      keys_q    <= key_state;
      ce_q      <= scan_clk_en;
      eval_pend <= col_wr || mask_wr || key_chg || ce_rise;
    end
  end

endmodule

// File: rtl/kbd_scan_rows.sv
module kbd_scan_rows #(
  parameter int ROWS = 5,
  parameter int COLS = 8,
  localparam int NKEYS = ROWS * COLS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             eval_pend,
  input  logic [NKEYS-1:0] keys_q,
  input  logic [COLS-1:0]  col_drive_n,
  output logic [ROWS-1:0]  row_latch_n
);

  logic [ROWS-1:0] row_hit;

  // One reduction per row: a pressed key in any driven column.
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign row_hit[r] = |(keys_q[r*COLS +: COLS] & ~col_drive_n);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         row_latch_n <= '1;
    else if (eval_pend) row_latch_n <= ~row_hit;
  end

endmodule

// File: rtl/kbd_scan_latch.sv
module kbd_scan_latch #(
  parameter int ROWS   = 5,
  parameter int COLS   = 8,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  localparam int NKEYS = ROWS * COLS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scan_clk_en,
  input  logic [NKEYS-1:0]  key_state,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr_en,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              kbd_irq
);

  logic [ROWS-1:0]  row_latch_n;
  logic [COLS-1:0]  col_drive_n;
  logic [NKEYS-1:0] keys_q;
  logic             kbd_mask;
  logic             col_wr;
  logic             mask_wr;
  logic             eval_pend;
  logic             irq_pending;

  kbd_scan_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ROWS(ROWS), .COLS(COLS)
  ) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (bus_addr),
    .bus_wr_en   (bus_wr_en),
    .bus_wdata   (bus_wdata),
    .row_latch_n (row_latch_n),
    .bus_rdata   (bus_rdata),
    .col_drive_n (col_drive_n),
    .kbd_mask    (kbd_mask),
    .col_wr      (col_wr),
    .mask_wr     (mask_wr),
    .irq_pending (irq_pending)
  );

  kbd_scan_trigger #(.NKEYS(NKEYS)) u_trig (
    .clk         (clk),
    .rst_n       (rst_n),
    .scan_clk_en (scan_clk_en),
    .key_state   (key_state),
    .col_wr      (col_wr),
    .mask_wr     (mask_wr),
    .keys_q      (keys_q),
    .eval_pend   (eval_pend)
  );

  kbd_scan_rows #(.ROWS(ROWS), .COLS(COLS)) u_rows (
    .clk         (clk),
    .rst_n       (rst_n),
    .eval_pend   (eval_pend),
    .keys_q      (keys_q),
    .col_drive_n (col_drive_n),
    .row_latch_n (row_latch_n)
  );

  assign kbd_irq = irq_pending && scan_clk_en;

endmodule

// File: rtl/kbd_scan_latch_chk.sv
module kbd_scan_latch_chk
  import kbd_scan_pkg::*;
#(
  parameter int ROWS   = 5,
  parameter int COLS   = 8,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scan_clk_en,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr_en,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              kbd_irq,
  input logic [ROWS-1:0]   row_latch_n,
  input logic [COLS-1:0]   col_drive_n,
  input logic              kbd_mask,
  input logic              eval_pend
);

  logic wr_cols, wr_mask, wr_other;
  assign wr_cols  = bus_wr_en && (16'(bus_addr) == OFS_COLS);
  assign wr_mask  = bus_wr_en && (16'(bus_addr) == OFS_MASK);
  assign wr_other = bus_wr_en && !wr_cols && !wr_mask;

  assert_col_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cols |=> (col_drive_n == $past(bus_wdata[COLS-1:0])));

  assert_latch_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !eval_pend |=> $stable(row_latch_n));

  assert_mask_bit0_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mask |=> (kbd_mask == $past(bus_wdata[0])));

  assert_stat_upper_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (16'(bus_addr) == OFS_STAT) |-> (bus_rdata[DATA_W-1:1] == '0));

  assert_irq_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    kbd_irq |-> (scan_clk_en && !kbd_mask && (row_latch_n != '1)));

  assert_ro_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_other |=> ($stable(col_drive_n) && $stable(kbd_mask)));

  assert_trigger_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cols || wr_mask) |=> eval_pend);

endmodule

bind kbd_scan_latch kbd_scan_latch_chk #(
  .ROWS(ROWS), .COLS(COLS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .scan_clk_en (scan_clk_en),
  .bus_addr    (bus_addr),
  .bus_wr_en   (bus_wr_en),
  .bus_wdata   (bus_wdata),
  .bus_rdata   (bus_rdata),
  .kbd_irq     (kbd_irq),
  .row_latch_n (row_latch_n),
  .col_drive_n (col_drive_n),
  .kbd_mask    (kbd_mask),
  .eval_pend   (eval_pend)
);

// File: tb/test_kbd_scan_latch.sv
`timescale 1ns/1ps
module test_kbd_scan_latch;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scan_clk_en = 1'b1;
  logic [39:0] key_state = '0;
  logic [7:0]  bus_addr = 8'h00;
  logic        bus_wr_en = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        kbd_irq;

  int n_checks = 0;
  int n_fails  = 0;

  always #4 clk = ~clk;

  kbd_scan_latch i_kbd_scan_latch (
    .clk(clk), .rst_n(rst_n), .scan_clk_en(scan_clk_en),
    .key_state(key_state), .bus_addr(bus_addr), .bus_wr_en(bus_wr_en),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .kbd_irq(kbd_irq)
  );

  // Behavioural reference: the latch is the row result of the key vector
  // and column drive as they were after the previous edge.
  logic [4:0]  m_latch = 5'h1f;
  logic [7:0]  m_col   = 8'hff;
  logic        m_mask  = 1'b0;
  logic [39:0] m_keys_prev = '0;

  function automatic logic [4:0] rows_of(input logic [39:0] k, input logic [7:0] c);
    logic [4:0] r = 5'h1f;
    for (int i = 0; i < 5; i++)
      for (int j = 0; j < 8; j++)
        if (k[i*8+j] && !c[j]) r[i] = 1'b0;
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_latch = 5'h1f; m_col = 8'hff; m_mask = 1'b0; m_keys_prev = '0;
    end else begin
      m_latch = rows_of(m_keys_prev, m_col);
      if (bus_wr_en && bus_addr == 8'h14) m_col  = bus_wdata[7:0];
      if (bus_wr_en && bus_addr == 8'h28) m_mask = bus_wdata[0];
      m_keys_prev = key_state;
    end
  end

  task automatic expect16(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic model_cmp();
    logic [15:0] exp_rd;
    logic        exp_irq;
    string       tag;
    exp_irq = (m_latch != 5'h1f) && !m_mask && scan_clk_en;
    case (bus_addr)
      8'h10: begin exp_rd = {11'd0, m_latch}; tag = "R3 row latch"; end
      8'h14: begin exp_rd = {8'd0, m_col}; tag = "R2 column reg"; end
      8'h20: begin exp_rd = {15'd0, (m_latch != 5'h1f) && !m_mask}; tag = "R6 status"; end
      8'h28: begin exp_rd = {15'd0, m_mask}; tag = "R5 mask"; end
      default: begin exp_rd = 16'h0; tag = "R8 unmapped read"; end
    endcase
    expect16(tag, bus_rdata, exp_rd);
    expect16("R7 kbd_irq", {15'd0, kbd_irq}, {15'd0, exp_irq});
  endtask

  task automatic tick();
    @(negedge clk);
    model_cmp();
  endtask

  task automatic set_bus(input logic [7:0] a, input logic w, input logic [15:0] d);
    bus_addr = a; bus_wr_en = w; bus_wdata = d;
  endtask

  task automatic read_expect(input logic [7:0] a, input logic [15:0] exp, input string tag);
    set_bus(a, 1'b0, 16'h0);
    tick();
    expect16(tag, bus_rdata, exp);
  endtask

  task automatic write_reg(input logic [7:0] a, input logic [15:0] d);
    set_bus(a, 1'b1, d);
    tick();
    set_bus(8'h10, 1'b0, 16'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog expired (R1..R9 incomplete) actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1: reset state
    read_expect(8'h10, 16'h001f, "R1 latch reset");
    read_expect(8'h14, 16'h00ff, "R1 column reset");
    read_expect(8'h28, 16'h0000, "R1 mask reset");
    read_expect(8'h20, 16'h0000, "R1 status reset");
    expect16("R1 irq reset", {15'd0, kbd_irq}, 16'h0);

    // R2: column register keeps 8 bits
    write_reg(8'h14, 16'hABFE);
    read_expect(8'h14, 16'h00fe, "R2 column store");

    // R9 / R3: key (2,0) pressed, column 0 driven
    set_bus(8'h10, 1'b0, 16'h0);
    key_state = 40'd1 << 16;
    tick();
    expect16("R9 latch before update", bus_rdata, 16'h001f);
    tick();
    expect16("R3 row2 hit", bus_rdata, 16'h001b);
    expect16("R7 irq on hit", {15'd0, kbd_irq}, 16'h1);
    read_expect(8'h20, 16'h0001, "R6 status on hit");

    // R3: key (1,3) in an undriven column has no effect
    key_state = (40'd1 << 16) | (40'd1 << 11);
    set_bus(8'h10, 1'b0, 16'h0);
    tick(); tick();
    expect16("R3 undriven column", bus_rdata, 16'h001b);

    // R9: drive columns 0 and 3
    set_bus(8'h14, 1'b1, 16'h00f6);
    tick();
    set_bus(8'h10, 1'b0, 16'h0);
    #1 expect16("R9 after column write", bus_rdata, 16'h001b);
    tick();
    expect16("R3 rows 1 and 2", bus_rdata, 16'h0019);

    // R5: only bit 0 of a mask write is kept
    write_reg(8'h28, 16'hfffe);
    read_expect(8'h28, 16'h0000, "R5 mask bit0 clear");
    write_reg(8'h28, 16'h0003);
    read_expect(8'h28, 16'h0001, "R5 mask bit0 set");
    read_expect(8'h20, 16'h0000, "R6 status masked");
    expect16("R7 irq masked", {15'd0, kbd_irq}, 16'h0);
    write_reg(8'h28, 16'h0000);
    tick();
    expect16("R7 irq unmasked", {15'd0, kbd_irq}, 16'h1);

    // R7: clock enable gates the interrupt
    scan_clk_en = 1'b0;
    #1 expect16("R7 irq gated by enable", {15'd0, kbd_irq}, 16'h0);
    read_expect(8'h20, 16'h0001, "R6 status independent of enable");
    scan_clk_en = 1'b1;
    tick();
    expect16("R4 enable rise keeps result", {15'd0, kbd_irq}, 16'h1);

    // R8: writes to read-only and unmapped offsets change nothing
    write_reg(8'h10, 16'h0000);
    write_reg(8'h20, 16'hffff);
    write_reg(8'h30, 16'h0000);
    write_reg(8'h00, 16'h0001);
    read_expect(8'h14, 16'h00f6, "R8 column untouched");
    read_expect(8'h28, 16'h0000, "R8 mask untouched");
    read_expect(8'h10, 16'h0019, "R8 latch untouched");
    read_expect(8'h30, 16'h0000, "R8 unmapped read zero");

    // R4: key release re-evaluates back to idle
    key_state = '0;
    set_bus(8'h10, 1'b0, 16'h0);
    tick(); tick();
    expect16("R4 release to idle", bus_rdata, 16'h001f);
    expect16("R7 irq idle", {15'd0, kbd_irq}, 16'h0);

    // Same cycle: column write together with a key change
    set_bus(8'h14, 1'b1, 16'h0000);
    key_state = (40'd1 << 39) | 40'd1;
    tick();
    set_bus(8'h10, 1'b0, 16'h0);
    tick();
    expect16("R4 column write with key change", bus_rdata, 16'h000e);

    // Same cycle: mask write together with a key change
    set_bus(8'h28, 1'b1, 16'h0001);
    key_state = 40'd1 << 8;
    tick();
    set_bus(8'h20, 1'b0, 16'h0);
    tick();
    expect16("R6 mask with key change", bus_rdata, 16'h0000);
    read_expect(8'h10, 16'h001d, "R3 row1 after coincident events");
    write_reg(8'h28, 16'h0000);

    // Mixed traffic against the reference model
    for (int it = 0; it < 4000; it++) begin
      logic [7:0] addrs [6] = '{8'h10, 8'h14, 8'h20, 8'h28, 8'h30, 8'h00};
      logic [7:0] a = addrs[$urandom_range(0, 5)];
      logic       w = ($urandom_range(0, 3) == 0);
      set_bus(a, w, 16'($urandom));
      if ($urandom_range(0, 2) == 0) key_state[$urandom_range(0, 39)] ^= 1'b1;
      if ($urandom_range(0, 9) == 0) scan_clk_en = ~scan_clk_en;
      if ($urandom_range(0, 49) == 0) key_state = '0;
      tick();
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule